// File: doc/BRIEF.md
# Serial DMA Register Front-End

This block is the register face of a serial-port DMA controller. Software programs it through a 32-bit write port that carries a register select, data and a per-bit write mask. It holds three address registers: one memory address and two peripheral addresses. It also holds a status word.

Writing a peripheral address also acts as a command. A write to the inbound register launches a 64-byte move from the peripheral into memory. A write to the outbound register launches a move the other way. Each launch is a one-cycle strobe that carries the stored addresses to the data mover. The block tracks whether a transfer is in flight. When the engine reports completion, the block raises an interrupt. Any write to the status word acknowledges that interrupt, and the written data is never stored.

Register selects are 0 for the memory address, 1 for inbound, 2 for outbound and 3 for status. Status bit 12 is the interrupt flag and status bit 0 is the busy flag. All other status bits read as zero.

Top module: `sdma_regs`

## Requirements
- R1: After reset, all four registers read zero, both start strobes are low and `irq` is low.
- R2: Every write to an address register (selects 0, 1 and 2) gives a bit the new data only where `bus_wmask` is 1. Every other bit keeps its old value.
- R3: A write to select 0 stores the masked value on `mem_addr` and read data. It produces no start strobe.
- R4: A write to select 1 while idle stores the masked value. In the following cycle, `pull_start` is high for exactly one cycle and `pull_paddr` carries the stored value.
- R5: A write to select 2 while idle stores the masked value. In the following cycle, `push_start` is high for exactly one cycle and `push_paddr` carries the stored value.
- R6: Status bit 0 reads 1 from the cycle the start strobe is high until the cycle after `xfer_done` is seen.
- R7: While busy, a write to select 1 or 2 still stores the masked value but produces no strobe.
- R8: `xfer_done` sampled while busy sets status bit 12 and `irq` from the next cycle on.
- R9: Any write to select 3 clears status bit 12 and `irq` in the next cycle, whatever its data or mask. The written data is not stored.
- R10: `xfer_done` while idle has no effect. When `xfer_done` arrives in the same cycle as a status write, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Write register select |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write enable |
| bus_raddr | input | 2 | Read register select |
| bus_rdata | output | 32 | Read data (combinational) |
| mem_addr | output | 32 | Stored memory address |
| pull_start | output | 1 | Start peripheral-to-memory transfer |
| pull_paddr | output | 32 | Stored inbound peripheral address |
| push_start | output | 1 | Start memory-to-peripheral transfer |
| push_paddr | output | 32 | Stored outbound peripheral address |
| xfer_done | input | 1 | Transfer-complete pulse from the engine |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 32-bit registers, the interrupt flag at bit 12 and the busy flag at bit 0. These values put the flag positions that software decodes directly in the read checks. Partial masks on 32-bit words exercise both halves of each register. The scoreboard pairs every expected launch with the strobe it sees. This exposes both missing strobes and extra strobes, such as a launch while busy or a launch caused by a memory-address write. The overlap of completion with acknowledge is driven in a single cycle to fix the priority.

// File: rtl/sdma_pkg.sv
// Shared register selects for the serial DMA register front-end.
package sdma_pkg;
    localparam int REG_AW = 2;
    localparam int N_ADDR_REGS = 3;

    typedef enum logic [REG_AW-1:0] {
        SEL_MEM  = 2'd0,
        SEL_PULL = 2'd1,
        SEL_PUSH = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/sdma_mask_reg.sv
// Bit-masked storage register.
// Assumes: d and m are valid whenever we is high; reset clears to zero.
module sdma_mask_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    input  logic [W-1:0] m,
    output logic [W-1:0] q
);
    // Merge new data into the selected bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= (q & ~m) | (d & m);
    end
endmodule

// File: rtl/sdma_ctrl.sv
// Launch and interrupt control: turns address-register writes into one-cycle
// start strobes, tracks the in-flight flag and keeps the interrupt flag.
// Assumes: done is meaningful only while busy; done outranks acknowledge.
module sdma_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_pull,
    input  logic req_push,
    input  logic done,
    input  logic ack,
    output logic pull_start,
    output logic push_start,
    output logic busy,
    output logic irq
);
    logic launch;
    assign launch = (req_pull || req_push) && !busy;

    // One-cycle strobes, issued only from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull_start <= 1'b0;
            push_start <= 1'b0;
        end else begin
            pull_start <= req_pull && !busy;
            push_start <= req_push && !busy;
        end
    end

    // In-flight flag: set on launch, cleared by completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (launch)
            busy <= 1'b1;
        else if (done)
            busy <= 1'b0;
    end

    // Interrupt flag: completion sets, a status write clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (done && busy)
            irq <= 1'b1;
        else if (ack)
            irq <= 1'b0;
    end
endmodule

// File: rtl/sdma_regs.sv
// Serial DMA register front-end top: decodes masked writes, keeps three address
// registers, forwards launches and completion to the control unit, and serves
// combinational register reads with live status flags.
// Assumes: at most one write per cycle; the engine pulses xfer_done once.
module sdma_regs #(
    parameter int DATA_W   = 32,
    parameter int IRQ_BIT  = 12,
    parameter int BUSY_BIT = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [sdma_pkg::REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic [DATA_W-1:0]          bus_wmask,
    input  logic [sdma_pkg::REG_AW-1:0] bus_raddr,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [DATA_W-1:0]          mem_addr,
    output logic                       pull_start,
    output logic [DATA_W-1:0]          pull_paddr,
    output logic                       push_start,
    output logic [DATA_W-1:0]          push_paddr,
    input  logic                       xfer_done,
    output logic                       irq
);
    import sdma_pkg::*;

    localparam int NREG = N_ADDR_REGS;

    logic [NREG-1:0]   reg_we;
    logic [DATA_W-1:0] addr_q [NREG];
    logic              busy;
    logic              stat_wr;
    logic [DATA_W-1:0] status_word;

    // One masked register per address slot.
    for (genvar i = 0; i < NREG; i++) begin : g_addr
        assign reg_we[i] = bus_wr && (bus_addr == REG_AW'(i));
        sdma_mask_reg #(.W(DATA_W)) u_reg (
            .clk (clk),
            .rst_n(rst_n),
            .we  (reg_we[i]),
            .d   (bus_wdata),
            .m   (bus_wmask),
            .q   (addr_q[i])
        );
    end

    assign stat_wr = bus_wr && (bus_addr == SEL_STAT);

    sdma_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_pull  (reg_we[SEL_PULL]),
        .req_push  (reg_we[SEL_PUSH]),
        .done      (xfer_done),
        .ack       (stat_wr),
        .pull_start(pull_start),
        .push_start(push_start),
        .busy      (busy),
        .irq       (irq)
    );

    assign mem_addr   = addr_q[SEL_MEM];
    assign pull_paddr = addr_q[SEL_PULL];
    assign push_paddr = addr_q[SEL_PUSH];

    // Live status: only the two flag positions are populated.
    always_comb begin
        status_word           = '0;
        status_word[IRQ_BIT]  = irq;
        status_word[BUSY_BIT] = busy;
    end

    // Read mux over the four selects.
    always_comb begin
        case (reg_sel_e'(bus_raddr))
            SEL_MEM:  bus_rdata = addr_q[SEL_MEM];
            SEL_PULL: bus_rdata = addr_q[SEL_PULL];
            SEL_PUSH: bus_rdata = addr_q[SEL_PUSH];
            default:  bus_rdata = status_word;
        endcase
    end
endmodule

// File: rtl/sdma_regs_chk.sv
// Protocol checker for sdma_regs, attached by bind.
module sdma_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic       xfer_done,
    input logic       pull_start,
    input logic       push_start,
    input logic       busy,
    input logic       irq
);
    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !pull_start && !push_start && !irq);
    p_mem_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> !pull_start && !push_start);
    p_pull_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && !busy) |=> pull_start);
    p_pull_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pull_start |=> !pull_start);
    p_push_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && !busy) |=> push_start);
    p_push_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_start |=> !push_start);
    p_strobe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_start || push_start) |-> busy);
    p_no_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != 2'd3 && busy) |=> !pull_start && !push_start);
    p_done_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && busy) |=> irq);
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3 && !(xfer_done && busy)) |=> !irq);
    p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !busy && !irq) |=> !irq);
    p_one_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pull_start, push_start}));
endmodule

bind sdma_regs sdma_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .xfer_done (xfer_done),
    .pull_start(pull_start),
    .push_start(push_start),
    .busy      (busy),
    .irq       (irq)
);

// File: tb/sdma_regs_tb.sv
`timescale 1ns/1ps
module sdma_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_wmask = '0;
    logic [1:0]  bus_raddr = '0;
    logic [31:0] bus_rdata, mem_addr, pull_paddr, push_paddr;
    logic        pull_start, push_start, irq;
    logic        xfer_done = 1'b0;

    int checks = 0;
    int errs = 0;
    bit finished = 0;

    // Expected strobe items: bit 32 = direction (1 outbound), low 32 = address.
    logic [32:0] exp_q [$];
    logic [31:0] m_reg [3];
    bit          m_busy = 0;

    always #2 clk = ~clk;

    sdma_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_raddr(bus_raddr),
        .bus_rdata(bus_rdata), .mem_addr(mem_addr), .pull_start(pull_start),
        .pull_paddr(pull_paddr), .push_start(push_start), .push_paddr(push_paddr),
        .xfer_done(xfer_done), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one write, with the expected strobe pushed to the scoreboard.
    task automatic wr(logic [1:0] sel, logic [31:0] d, logic [31:0] m);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = sel; bus_wdata = d; bus_wmask = m;
        if (sel != 2'd3) begin
            m_reg[sel] = (m_reg[sel] & ~m) | (d & m);
            if (sel != 2'd0 && !m_busy) begin
                exp_q.push_back({sel == 2'd2, m_reg[sel]});
                m_busy = 1;
            end
        end
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic done_pulse(bit with_ack);
        @(negedge clk);
        xfer_done = 1'b1;
        if (with_ack) begin
            bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = '1; bus_wmask = '1;
        end
        m_busy = 0;
        @(posedge clk);
        #1 xfer_done = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_raddr = sel;
        #1 chk(tag, bus_rdata, exp);
    endtask

    // Monitor: every strobe must match the next expected item.
    always @(negedge clk) begin
        if (rst_n && (pull_start || push_start)) begin
            checks++;
            if (pull_start && push_start) begin
                errs++; $display("FAIL R4 both strobes actual=11 expected=one");
            end else if (exp_q.size() == 0) begin
                errs++;
                $display("FAIL R3/R7 unexpected strobe actual=%b%b expected=none", pull_start, push_start);
            end else begin
                logic [32:0] e;
                logic [31:0] a;
                e = exp_q.pop_front();
                a = push_start ? push_paddr : pull_paddr;
                if ({push_start, a} !== e) begin
                    errs++;
                    $display("FAIL R4/R5 strobe actual=%h expected=%h", {push_start, a}, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) m_reg[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 4; i++) rd(2'(i), 32'h0, "R1 reset read");
        chk("R1 irq reset", {31'b0, irq}, 32'h0);

        // R2 / R3 memory address: full then partial mask, no strobe
        wr(2'd0, 32'hA5A5_1234, 32'hFFFF_FFFF);
        rd(2'd0, 32'hA5A5_1234, "R3 mem store");
        wr(2'd0, 32'hFFFF_0000, 32'h00FF_00FF);
        rd(2'd0, 32'hA5FF_1200, "R2 mem partial mask");
        chk("R3 mem_addr port", mem_addr, 32'hA5FF_1200);
        chk("R3 no strobe queued", exp_q.size(), 0);

        // R4 inbound launch, R6 busy
        wr(2'd1, 32'h0000_1F40, 32'hFFFF_FFFF);
        rd(2'd3, 32'h0000_0001, "R6 busy set");
        rd(2'd1, 32'h0000_1F40, "R4 pull stored");
        chk("R4 strobe consumed", exp_q.size(), 0);

        // R7 outbound write while busy: stored, no strobe
        wr(2'd2, 32'h0BAD_0000, 32'hFFFF_FFFF);
        rd(2'd2, 32'h0BAD_0000, "R7 stored while busy");

        // R8 completion
        done_pulse(0);
        rd(2'd3, 32'h0000_1000, "R8 irq flag set, busy clear");
        chk("R8 irq pin", {31'b0, irq}, 32'h1);

        // R9 acknowledge with zero mask
        wr(2'd3, 32'hFFFF_FFFF, 32'h0000_0000);
        rd(2'd3, 32'h0000_0000, "R9 ack clears");
        chk("R9 irq pin low", {31'b0, irq}, 32'h0);

        // R10 done while idle ignored
        done_pulse(0);
        m_busy = 0;
        rd(2'd3, 32'h0000_0000, "R10 idle done ignored");
        chk("R10 irq idle", {31'b0, irq}, 32'h0);

        // R5 outbound launch with partial mask
        wr(2'd2, 32'h0000_00C0, 32'h0000_FFFF);
        rd(2'd2, 32'h0BAD_00C0, "R5 push partial store");
        rd(2'd3, 32'h0000_0001, "R6 busy outbound");
        done_pulse(0);
        rd(2'd3, 32'h0000_1000, "R8 second completion");
        wr(2'd3, 32'h0, 32'h0);
        chk("R9 second ack", {31'b0, irq}, 32'h0);

        // R10 done coincident with ack: flag set
        wr(2'd1, 32'h0000_0080, 32'h0000_00FF);
        done_pulse(1);
        rd(2'd3, 32'h0000_1000, "R10 done beats ack");
        wr(2'd3, 32'h1234_5678, 32'hFFFF_FFFF);
        rd(2'd3, 32'h0000_0000, "R9 data not stored");

        repeat (3) @(negedge clk);
        chk("R4 all expected strobes seen", exp_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule